// File: doc/BRIEF.md
# Header Field Slice Extractor

This block builds the field portion of a packet classification key. Software programs a small bank of slice configuration words. Each word names an anchor and a distance from that anchor. The anchor is either the first byte after the link-layer header or the first byte after the network-layer header. The distance counts 16-bit words. As the packet's bytes stream past, each slice picks up the two bytes at its target position in network order, most significant byte first.

Header boundaries are not found here. An upstream parser presents the byte positions at which the link-layer and network-layer headers end, and holds them steady for the whole packet. When the final byte is accepted, the block publishes every slice's 16-bit field together with a per-slice valid flag. It raises a one-cycle done strobe and holds the key until the next packet begins. Configuration writes may arrive at any time. A packet only ever uses the configuration that was in place when its first byte arrived.

Top module: `hfx_slice_extract`

## Requirements
- R1: After reset, key_done is low, key_valid and key_data are all zero, and slice_cnt is zero.
- R2: A slice whose anchor code (config bits [OFS_W+1:OFS_W]) is 2'b01 targets byte position l2_end + 2*offset, where offset is config bits [OFS_W-1:0]. Its field is {byte at that position, byte at position+1}, and its valid flag is 1.
- R3: Anchor code 2'b10 works the same way as R2, but counts from l3_end.
- R4: A slice whose anchor code is 2'b00 or 2'b11 is unused, and an all-zero word is one such case. It reports data zero and valid low.
- R5: If a slice's second target byte lies at or past the packet length, the slice reports data zero and valid low. This holds even when its first byte was present.
- R6: The key and its flags stay stable from the done strobe until the next start-of-packet byte is accepted. After that byte, all valid flags and all data are zero.
- R7: A configuration write made while a packet is in flight does not affect that packet. It is used from the next packet on.
- R8: Slice k's configuration register is at byte address BASE_ADDR + 4*k. A write to a misaligned address or to an address outside the bank changes nothing.
- R9: key_done is high for exactly one cycle, in the cycle after the end-of-packet byte is accepted. This includes a packet of one byte whose start and end marks coincide.
- R10: Cycles with in_valid low do not advance the byte position.
- R11: slice_cnt equals the number of slices with anchor code 2'b01 or 2'b10 in the configuration used by the most recent packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | ADDR_W | Byte address of the configuration write |
| cfg_wr_data | input | OFS_W+2 | Configuration word: anchor code above offset |
| in_valid | input | 1 | A packet byte is present |
| in_sop | input | 1 | This byte is the first of a packet |
| in_eop | input | 1 | This byte is the last of a packet |
| in_byte | input | 8 | Packet byte |
| l2_end | input | POS_W | Position of the first byte after the link-layer header |
| l3_end | input | POS_W | Position of the first byte after the network-layer header |
| key_data | output | 16*NUM_SLICES | Extracted fields, slice k at bits [16k+15:16k] |
| key_valid | output | NUM_SLICES | Per-slice valid flag |
| key_done | output | 1 | One-cycle strobe: key updated |
| slice_cnt | output | $clog2(NUM_SLICES+1) | Number of active slices |

## Verification
The bench targets fields that straddle the end of the packet. A design that publishes a half-captured field would report a nonzero value or a raised valid flag there. A one-byte packet checks that the start and end marks on the same byte still produce a done strobe and an empty key. Idle cycles are inserted inside packets, so a design whose position counter advances on idle cycles would return shifted bytes. A configuration write is issued in mid-packet. A design without staged configuration would mix the old and new anchors in that packet's key. Writes to misaligned, below-base and beyond-bank addresses are applied. A design that decodes the address loosely would corrupt a live slice or change slice_cnt.

// File: rtl/hfx_pkg.sv
package hfx_pkg;

   localparam int FLD_W  = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ANC_OFF  = 2'b00,
      ANC_L2   = 2'b01,
      ANC_L3   = 2'b10,
      ANC_RSVD = 2'b11
   } anchor_e;

   function automatic logic anchor_live(input logic [1:0] code);
      return (code == ANC_L2) || (code == ANC_L3);
   endfunction

endpackage

// File: rtl/hfx_pos_ctr.sv
module hfx_pos_ctr #(
   parameter int POS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             sop,
   output logic [POS_W-1:0] pos_cur
);

   localparam logic [POS_W-1:0] POS_MAX = '1;

   logic [POS_W-1:0] cnt_q;

   assign pos_cur = sop ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (beat) begin
         cnt_q <= (pos_cur == POS_MAX) ? POS_MAX : pos_cur + 1'b1;
      end
   end

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beat |=> $stable(cnt_q));

endmodule

// File: rtl/hfx_cfg_bank.sv
module hfx_cfg_bank #(
   parameter int               NUM_SLICES = 9,
   parameter int               CFG_W      = 7,
   parameter int               ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
   localparam int              CNT_W      = $clog2(NUM_SLICES + 1)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    wr_addr,
   input  logic [CFG_W-1:0]                     wr_data,
   input  logic                                 pkt_start,
   output logic [NUM_SLICES-1:0][CFG_W-1:0]     cfg_use,
   output logic [CNT_W-1:0]                     act_cnt
);

   import hfx_pkg::*;

   localparam int IDX_W = ADDR_W - 2;

   logic [NUM_SLICES-1:0][CFG_W-1:0] shadow_q;
   logic [NUM_SLICES-1:0][CFG_W-1:0] live_q;
   logic [ADDR_W-1:0]                rel_addr;
   logic [IDX_W-1:0]                 wr_idx;
   logic                             addr_hit;

   assign rel_addr = wr_addr - BASE_ADDR;
   assign wr_idx   = rel_addr[ADDR_W-1:2];
   assign addr_hit = wr_en && (rel_addr[1:0] == 2'b00)
                     && (int'(wr_idx) < NUM_SLICES);

   generate
      for (genvar k = 0; k < NUM_SLICES; k++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q[k] <= '0;
            end else if (addr_hit && (int'(wr_idx) == k)) begin
               shadow_q[k] <= wr_data;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (pkt_start) begin
         live_q <= shadow_q;
      end
   end

   assign cfg_use = pkt_start ? shadow_q : live_q;

   always_comb begin
      act_cnt = '0;
      for (int k = 0; k < NUM_SLICES; k++) begin
         if (anchor_live(live_q[k][CFG_W-1 -: 2])) begin
            act_cnt = act_cnt + 1'b1;
         end
      end
   end

   // R7
   live_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_start |=> $stable(live_q));

   // R11
   act_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(act_cnt) <= NUM_SLICES);

endmodule

// File: rtl/hfx_slice.sv
module hfx_slice #(
   parameter int  POS_W = 11,
   parameter int  OFS_W = 5,
   localparam int CFG_W = OFS_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg,
   input  logic             beat,
   input  logic             sop,
   input  logic [POS_W-1:0] pos,
   input  logic [7:0]       din,
   input  logic [POS_W-1:0] l2_end,
   input  logic [POS_W-1:0] l3_end,
   output logic             fld_ok,
   output logic [15:0]      fld_data
);

   import hfx_pkg::*;

   logic [1:0]       code;
   logic [OFS_W-1:0] ofs;
   logic             live;
   logic [POS_W-1:0] anc_pos;
   logic [POS_W:0]   tgt_hi;
   logic [POS_W:0]   tgt_lo;
   logic             hit_hi;
   logic             hit_lo;

   logic             got_hi_q, got_lo_q;
   logic [7:0]       hi_q, lo_q;
   logic             got_hi_n, got_lo_n;
   logic [7:0]       hi_n, lo_n;

   assign code    = cfg[CFG_W-1 -: 2];
   assign ofs     = cfg[OFS_W-1:0];
   assign live    = anchor_live(code);
   assign anc_pos = (code == ANC_L3) ? l3_end : l2_end;
   assign tgt_hi  = {1'b0, anc_pos} + (POS_W+1)'({ofs, 1'b0});
   assign tgt_lo  = tgt_hi + 1'b1;
   assign hit_hi  = beat && live && ({1'b0, pos} == tgt_hi);
   assign hit_lo  = beat && live && ({1'b0, pos} == tgt_lo);

   always_comb begin
      got_hi_n = sop ? 1'b0 : got_hi_q;
      got_lo_n = sop ? 1'b0 : got_lo_q;
      hi_n     = sop ? 8'h00 : hi_q;
      lo_n     = sop ? 8'h00 : lo_q;
      if (hit_hi) begin
         got_hi_n = 1'b1;
         hi_n     = din;
      end
      if (hit_lo) begin
         got_lo_n = 1'b1;
         lo_n     = din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_hi_q <= 1'b0;
         got_lo_q <= 1'b0;
         hi_q     <= '0;
         lo_q     <= '0;
      end else if (beat) begin
         got_hi_q <= got_hi_n;
         got_lo_q <= got_lo_n;
         hi_q     <= hi_n;
         lo_q     <= lo_n;
      end
   end

   assign fld_ok   = got_hi_n && got_lo_n;
   assign fld_data = fld_ok ? {hi_n, lo_n} : 16'h0000;

   // R2 R3: the low byte follows the high byte, never precedes it
   lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !sop && got_lo_q) |-> got_hi_q);

endmodule

// File: rtl/hfx_slice_extract.sv
module hfx_slice_extract #(
   parameter int               NUM_SLICES = 9,
   parameter int               OFS_W      = 5,
   parameter int               POS_W      = 11,
   parameter int               ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
   localparam int              CFG_W      = OFS_W + 2,
   localparam int              KEY_W      = 16 * NUM_SLICES,
   localparam int              CNT_W      = $clog2(NUM_SLICES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr_en,
   input  logic [ADDR_W-1:0]     cfg_wr_addr,
   input  logic [CFG_W-1:0]      cfg_wr_data,
   input  logic                  in_valid,
   input  logic                  in_sop,
   input  logic                  in_eop,
   input  logic [7:0]            in_byte,
   input  logic [POS_W-1:0]      l2_end,
   input  logic [POS_W-1:0]      l3_end,
   output logic [KEY_W-1:0]      key_data,
   output logic [NUM_SLICES-1:0] key_valid,
   output logic                  key_done,
   output logic [CNT_W-1:0]      slice_cnt
);

   generate
      if (NUM_SLICES < 1) begin : g_bad_n
         $error("NUM_SLICES must be at least 1");
      end
      if (OFS_W + 1 > POS_W) begin : g_bad_ofs
         $error("OFS_W too wide for POS_W");
      end
      if (ADDR_W < 3 || (4 * NUM_SLICES) > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W cannot hold the slice bank");
      end
   endgenerate

   logic                             beat;
   logic                             sop_beat;
   logic                             eop_beat;
   logic [POS_W-1:0]                 pos_cur;
   logic [NUM_SLICES-1:0][CFG_W-1:0] cfg_use;
   logic [NUM_SLICES-1:0]            fld_ok;
   logic [KEY_W-1:0]                 fld_data;

   logic [KEY_W-1:0]                 key_data_q;
   logic [NUM_SLICES-1:0]            key_valid_q;
   logic                             key_done_q;

   assign beat     = in_valid;
   assign sop_beat = in_valid && in_sop;
   assign eop_beat = in_valid && in_eop;

   hfx_pos_ctr #(.POS_W(POS_W)) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat    (beat),
      .sop     (in_sop),
      .pos_cur (pos_cur)
   );

   hfx_cfg_bank #(
      .NUM_SLICES (NUM_SLICES),
      .CFG_W      (CFG_W),
      .ADDR_W     (ADDR_W),
      .BASE_ADDR  (BASE_ADDR)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wr_addr   (cfg_wr_addr),
      .wr_data   (cfg_wr_data),
      .pkt_start (sop_beat),
      .cfg_use   (cfg_use),
      .act_cnt   (slice_cnt)
   );

   generate
      for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
         hfx_slice #(.POS_W(POS_W), .OFS_W(OFS_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (cfg_use[k]),
            .beat     (beat),
            .sop      (in_sop),
            .pos      (pos_cur),
            .din      (in_byte),
            .l2_end   (l2_end),
            .l3_end   (l3_end),
            .fld_ok   (fld_ok[k]),
            .fld_data (fld_data[16*k +: 16])
         );

         // R4 R5
         invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !key_valid[k] |-> (key_data[16*k +: 16] == 16'h0000));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_data_q  <= '0;
         key_valid_q <= '0;
         key_done_q  <= 1'b0;
      end else begin
         key_done_q <= eop_beat;
         if (eop_beat) begin
            key_data_q  <= fld_data;
            key_valid_q <= fld_ok;
         end else if (sop_beat) begin
            key_data_q  <= '0;
            key_valid_q <= '0;
         end
      end
   end

   assign key_data  = key_data_q;
   assign key_valid = key_valid_q;
   assign key_done  = key_done_q;

   // R9
   done_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_done |-> $past(in_valid && in_eop));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_done && !(in_valid && in_eop)) |=> !key_done);

   // R6
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && (in_sop || in_eop)) |=> ($stable(key_data) && $stable(key_valid)));

endmodule

// File: tb/hfx_slice_extract_bench.sv
module hfx_slice_extract_bench;

   localparam int NS    = 9;
   localparam int OFS_W = 5;
   localparam int POS_W = 11;
   localparam int AW    = 8;
   localparam logic [AW-1:0] BASE = 8'h40;
   localparam int CW    = OFS_W + 2;
   localparam int CNTW  = $clog2(NS + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr_en = 1'b0;
   logic [AW-1:0]     cfg_wr_addr = '0;
   logic [CW-1:0]     cfg_wr_data = '0;
   logic              in_valid = 1'b0;
   logic              in_sop = 1'b0;
   logic              in_eop = 1'b0;
   logic [7:0]        in_byte = '0;
   logic [POS_W-1:0]  l2_end = '0;
   logic [POS_W-1:0]  l3_end = '0;
   logic [16*NS-1:0]  key_data;
   logic [NS-1:0]     key_valid;
   logic              key_done;
   logic [CNTW-1:0]   slice_cnt;

   int checks = 0;
   int errors = 0;
   int seed   = 0;
   logic [CW-1:0] model_cfg [NS];

   always #4 clk = ~clk;

   hfx_slice_extract #(
      .NUM_SLICES (NS), .OFS_W (OFS_W), .POS_W (POS_W),
      .ADDR_W (AW), .BASE_ADDR (BASE)
   ) u_hfx_slice_extract (
      .clk (clk), .rst_n (rst_n),
      .cfg_wr_en (cfg_wr_en), .cfg_wr_addr (cfg_wr_addr), .cfg_wr_data (cfg_wr_data),
      .in_valid (in_valid), .in_sop (in_sop), .in_eop (in_eop), .in_byte (in_byte),
      .l2_end (l2_end), .l3_end (l3_end),
      .key_data (key_data), .key_valid (key_valid), .key_done (key_done),
      .slice_cnt (slice_cnt)
   );

   function automatic logic [7:0] pb(input int i);
      return 8'((i * 37 + seed * 11 + 5) & 255);
   endfunction

   function automatic logic [CW-1:0] mk(input logic [1:0] code, input int ofs);
      return {code, OFS_W'(ofs)};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [AW-1:0] addr, input logic [CW-1:0] val);
      logic [AW-1:0] rel;
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_addr = addr;
      cfg_wr_data = val;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      rel = addr - BASE;
      // R8: only aligned addresses inside the bank reach a slice
      if (rel[1:0] == 2'b00 && int'(rel[AW-1:2]) < NS) model_cfg[int'(rel[AW-1:2])] = val;
   endtask

   task automatic check_key(input int len, input int l2, input int l3,
                            input logic [CW-1:0] snap [NS], input string tag);
      int ecnt = 0;
      logic [16*NS-1:0] held_d;
      logic [NS-1:0]    held_v;
      // R9: done strobe one cycle after the end byte
      chk({"R9 done high ", tag}, 32'(key_done), 32'd1);
      for (int k = 0; k < NS; k++) begin
         logic [1:0] code;
         int t;
         logic ev;
         logic [15:0] ed;
         string rq;
         code = snap[k][CW-1 -: 2];
         ev = 1'b0;
         ed = 16'h0;
         if (code == 2'b01 || code == 2'b10) begin
            ecnt++;
            t = ((code == 2'b01) ? l2 : l3) + 2 * int'(snap[k][OFS_W-1:0]);
            if (t + 1 < len) begin
               ev = 1'b1;
               ed = {pb(t), pb(t + 1)};
               rq = (code == 2'b01) ? "R2" : "R3";
            end else begin
               rq = "R5";
            end
         end else begin
            rq = "R4";
         end
         chk($sformatf("%s slice %0d valid %s", rq, k, tag), 32'(key_valid[k]), 32'(ev));
         chk($sformatf("%s slice %0d data %s", rq, k, tag), 32'(key_data[16*k +: 16]), 32'(ed));
      end
      // R11
      chk({"R11 slice count ", tag}, 32'(slice_cnt), 32'(ecnt));
      held_d = key_data;
      held_v = key_valid;
      repeat (3) @(negedge clk);
      // R9: strobe lasts one cycle; R6: key held while idle
      chk({"R9 done low ", tag}, 32'(key_done), 32'd0);
      chk({"R6 data held ", tag}, 32'(held_d == key_data), 32'd1);
      chk({"R6 valid held ", tag}, 32'(held_v == key_valid), 32'd1);
   endtask

   task automatic send_packet(input int len, input int l2, input int l3,
                              input bit gaps, input bit midwr,
                              input logic [AW-1:0] mw_addr, input logic [CW-1:0] mw_val,
                              input string tag);
      logic [CW-1:0] snap [NS];
      for (int k = 0; k < NS; k++) snap[k] = model_cfg[k];
      l2_end = POS_W'(l2);
      l3_end = POS_W'(l3);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i == 1) begin
            // R6: cleared once the start byte is accepted
            chk({"R6 cleared at start ", tag}, 32'(key_valid), 32'd0);
            chk({"R6 data cleared ", tag}, 32'(key_data == '0), 32'd1);
         end
         in_valid = 1'b1;
         in_sop   = (i == 0);
         in_eop   = (i == len - 1);
         in_byte  = pb(i);
         if (midwr && i == 4) begin
            cfg_wr_en = 1'b1; cfg_wr_addr = mw_addr; cfg_wr_data = mw_val;
            model_cfg[int'((mw_addr - BASE) >> 2)] = mw_val;
         end
         if (midwr && i == 5) cfg_wr_en = 1'b0;
         if (gaps && (i % 3 == 1) && i != len - 1) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_byte = 8'hEE;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; cfg_wr_en = 1'b0;
      check_key(len, l2, l3, snap, tag);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      // R1
      chk("R1 done after reset", 32'(key_done), 32'd0);
      chk("R1 valid after reset", 32'(key_valid), 32'd0);
      chk("R1 data after reset", 32'(key_data == '0), 32'd1);
      chk("R1 count after reset", 32'(slice_cnt), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_basic();
      // R2 R3 R4 R11: four link-anchored words, two network-anchored, rest unused
      write_cfg(BASE + 0,  mk(2'b01, 6));
      write_cfg(BASE + 4,  mk(2'b01, 7));
      write_cfg(BASE + 8,  mk(2'b01, 8));
      write_cfg(BASE + 12, mk(2'b01, 9));
      write_cfg(BASE + 16, mk(2'b10, 0));
      write_cfg(BASE + 20, mk(2'b10, 1));
      seed = 1;
      send_packet(60, 14, 34, 1'b0, 1'b0, '0, '0, "basic");
      seed = 2;
      send_packet(64, 18, 38, 1'b0, 1'b0, '0, '0, "tagged");
   endtask

   task automatic t_gaps();
      // R10
      seed = 3;
      send_packet(60, 14, 34, 1'b1, 1'b0, '0, '0, "R10 gaps");
   endtask

   task automatic t_beyond();
      // R5: slice 6 high byte is the last byte, slice 7 far past the end; R4: code 11
      write_cfg(BASE + 24, mk(2'b10, 12));
      write_cfg(BASE + 28, mk(2'b10, 20));
      write_cfg(BASE + 32, mk(2'b11, 3));
      seed = 4;
      send_packet(59, 14, 34, 1'b0, 1'b0, '0, '0, "R5 short");
      seed = 5;
      send_packet(1, 14, 34, 1'b0, 1'b0, '0, '0, "R5 R9 one byte");
   endtask

   task automatic t_midwrite();
      // R7: change slice 0 while the packet runs
      seed = 6;
      send_packet(60, 14, 34, 1'b0, 1'b1, BASE, mk(2'b10, 2), "R7 during");
      seed = 7;
      send_packet(60, 14, 34, 1'b0, 1'b0, '0, '0, "R7 after");
   endtask

   task automatic t_decode();
      // R8: misaligned, below base and beyond bank writes do nothing
      write_cfg(BASE + 1, mk(2'b01, 1));
      write_cfg(BASE - 4, mk(2'b01, 1));
      write_cfg(BASE + 4 * NS, mk(2'b01, 1));
      write_cfg(BASE + 4 * NS + 2, mk(2'b10, 1));
      write_cfg(BASE + 32, mk(2'b00, 0));
      seed = 8;
      send_packet(60, 14, 34, 1'b0, 1'b0, '0, '0, "R8 decode");
   endtask

   initial begin
      for (int k = 0; k < NS; k++) model_cfg[k] = '0;
      t_reset();
      t_basic();
      t_gaps();
      t_beyond();
      t_midwrite();
      t_decode();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule